// File: doc/BRIEF.md
# TPM Header and Write-Data Front End with Dual Chip Select

This block listens on a serial data line that two logical targets share. One active-low select (`gen_csb`) belongs to ordinary flash-style traffic, which is handled elsewhere. The other (`tpm_csb`) belongs to TPM transactions, which this block handles. The two functions stay enabled together. Only the select lines tell them apart, so the host must never drive both selects low at once. The block records that situation as a sticky protocol error.

While `tpm_csb` is low, bits are taken on each rising edge of `sck` (mode 0), most significant bit first. The first four bytes form the header. Byte 0 is the command: bit 7 is set for a read and clear for a write, and bits 5:0 hold the transfer size minus one. Bytes 1 to 3 are a 24-bit address, high byte first. The header crosses into the core clock domain through a small gray-pointer FIFO. Its non-empty state is a level output to the core.

For write commands, the bytes after the header go into a 4-entry write FIFO, limited to the size given in the command. The core drains that FIFO across the same kind of crossing. The write FIFO raises no interrupt. When a byte or a header finds its buffer full, it is dropped and a sticky overflow flag is set.

Top module: `tpmfe_top`

## Requirements
- R1: While `tpm_csb` is low, bits shift in MSB first on rising `sck`. Bytes 0..3 appear on `hdr_data` as {command, address[23:16], address[15:8], address[7:0]}, with byte 0 in bits 31:24.
- R2: When command bit 7 is 0 (write), bytes after the header are pushed into the write FIFO in order. At most (bits 5:0 + 1) bytes are pushed, and any further bytes are ignored.
- R3: When command bit 7 is 1 (read), no byte of the transaction reaches the write FIFO.
- R4: `hdr_avail` is a level signal. It stays high while the header buffer holds an entry and falls only after the last entry is popped with `hdr_pop`. The buffer holds HDR_DEPTH = 2 headers.
- R5: The write FIFO holds 4 bytes. A data byte that arrives while it is full is dropped and sets the sticky `wr_ovf`.
- R6: A header that arrives while the header buffer is full is dropped together with the write data of its transaction, and `wr_ovf` is set.
- R7: Raising `tpm_csb` discards any partly received byte and header. The next transaction starts again at header byte 0.
- R8: `sck` and `sdi` activity while only `gen_csb` is low changes neither the header buffer nor the write FIFO.
- R9: If both selects are seen low together in the core domain, `cs_conflict` goes high and stays high until reset.
- R10: After reset, `hdr_avail`, `wdata_avail`, `wr_ovf` and `cs_conflict` are 0.
- R11: Popping an empty header buffer or an empty write FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| sck | input | 1 | Serial clock, idle low |
| gen_csb | input | 1 | Active-low select of the generic SPI target |
| tpm_csb | input | 1 | Active-low select of the TPM target |
| sdi | input | 1 | Serial data from the host |
| hdr_avail | output | 1 | Header buffer non-empty (level) |
| hdr_data | output | 32 | Oldest header {cmd, addr} |
| hdr_pop | input | 1 | Core removes the oldest header |
| wdata_avail | output | 1 | Write FIFO non-empty |
| wdata | output | 8 | Oldest write byte |
| wdata_pop | input | 1 | Core removes the oldest write byte |
| wr_ovf | output | 1 | Sticky overflow flag |
| cs_conflict | output | 1 | Sticky flag: both selects were low together |

## Verification
The hardest case to reach from the ports is a header that arrives while the header buffer is full. To get there, the core must leave two earlier headers unpopped while the serial side, whose pointer view only advances on `sck` edges, completes a third header. The bench does this with a directed sequence of three transactions and no pops in between. It then checks that only the first two headers come out and that the third transaction's write bytes never appear. Random write and read transactions with random sizes and byte counts cover the size window. Directed runs cover the 4-byte overflow, a select raised in the middle of a byte, and traffic under the generic select.

// File: rtl/tpmfe_pkg.sv
package tpmfe_pkg;
   localparam int HDR_BYTES = 4;
   localparam int HDR_W     = 8 * HDR_BYTES;
   localparam int BYTE_W    = 8;

   typedef struct packed {
      logic        rd;
      logic        rsvd;
      logic [5:0]  szm1;
      logic [23:0] addr;
   } tpm_hdr_t;
endpackage

// File: rtl/tpmfe_sync.sv
module tpmfe_sync #(
   parameter int          STAGES  = 2,
   parameter int          W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tpmfe_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tpmfe_afifo.sv
module tpmfe_afifo #(
   parameter int W           = 8,
   parameter int DEPTH       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic         wclk,
   input  logic         wrst_n,
   input  logic         wpush,
   input  logic [W-1:0] wdata,
   output logic         wfull,
   input  logic         rclk,
   input  logic         rrst_n,
   input  logic         rpop,
   output logic [W-1:0] rdata,
   output logic         rempty
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam logic [PW-1:0] FULL_X = PW'(3) << (PW - 2);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("tpmfe_afifo: DEPTH must be a power of two, at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("tpmfe_afifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wbin, wgray, rbin, rgray;
   logic [PW-1:0] rgray_w, wgray_r;
   logic [PW-1:0] wbin_nx, rbin_nx;

   // write side
   assign wfull   = (wgray ^ rgray_w) == FULL_X;
   assign wbin_nx = wbin + PW'(1);

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wpush && !wfull) begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   always_ff @(posedge wclk) begin
      if (wpush && !wfull) mem[wbin[AW-1:0]] <= wdata;
   end

   // read side
   assign rempty  = rgray == wgray_r;
   assign rbin_nx = rbin + PW'(1);
   assign rdata   = mem[rbin[AW-1:0]];

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rpop && !rempty) begin
         rbin  <= rbin_nx;
         rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
   end

   tpmfe_sync #(.STAGES(SYNC_STAGES), .W(PW)) u_r2w (
      .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));
   tpmfe_sync #(.STAGES(SYNC_STAGES), .W(PW)) u_w2r (
      .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));

   // R5
   no_overflow_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
      wpush && wfull |=> $stable(wbin));
   // R11
   empty_pop_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
      rpop && rempty |=> $stable(rbin));
endmodule

// File: rtl/tpmfe_rx.sv
module tpmfe_rx
   import tpmfe_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic              sck,
   input  logic              clr_n,
   input  logic              sdi,
   input  logic              hdr_full,
   output logic              hdr_push,
   output logic [HDR_W-1:0]  hdr_word,
   output logic              dat_push,
   output logic [BYTE_W-1:0] dat_byte
);
   if ((1 << CNT_W) - 1 <= HDR_BYTES + 64) begin : g_bad_cnt
      $error("tpmfe_rx: CNT_W too small for header plus 64 data bytes");
   end

   logic [2:0]       bitcnt;
   logic [CNT_W-1:0] bytecnt;
   logic [HDR_W-1:0] shreg, next_sh;
   logic             is_wr, dropped, byte_done, in_data;
   logic [5:0]       szm1;
   logic [CNT_W-1:0] didx;
   tpm_hdr_t         hdr_now;

   assign next_sh   = {shreg[HDR_W-2:0], sdi};
   assign hdr_now   = tpm_hdr_t'(next_sh);
   assign byte_done = bitcnt == 3'd7;
   assign in_data   = bytecnt >= CNT_W'(HDR_BYTES);
   assign didx      = bytecnt - CNT_W'(HDR_BYTES);

   assign hdr_word  = next_sh;
   assign dat_byte  = next_sh[BYTE_W-1:0];
   assign hdr_push  = byte_done && bytecnt == CNT_W'(HDR_BYTES - 1);
   assign dat_push  = byte_done && in_data && is_wr && !dropped &&
                      didx <= CNT_W'(szm1);

   always_ff @(posedge sck or negedge clr_n) begin
      if (!clr_n) begin
         shreg   <= '0;
         bitcnt  <= '0;
         bytecnt <= '0;
         is_wr   <= 1'b0;
         dropped <= 1'b0;
         szm1    <= '0;
      end else begin
         shreg  <= next_sh;
         bitcnt <= bitcnt + 3'd1;
         if (byte_done && bytecnt != '1) bytecnt <= bytecnt + CNT_W'(1);
         if (hdr_push) begin
            is_wr   <= !hdr_now.rd;
            szm1    <= hdr_now.szm1;
            dropped <= hdr_full;
         end
      end
   end

   // R2
   data_after_hdr_chk: assert property (@(posedge sck) disable iff (!clr_n)
      hdr_push |=> !dat_push);
endmodule

// File: rtl/tpmfe_top.sv
module tpmfe_top
   import tpmfe_pkg::*;
#(
   parameter int HDR_DEPTH   = 2,
   parameter int WR_DEPTH    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              gen_csb,
   input  logic              tpm_csb,
   input  logic              sdi,
   output logic              hdr_avail,
   output logic [HDR_W-1:0]  hdr_data,
   input  logic              hdr_pop,
   output logic              wdata_avail,
   output logic [BYTE_W-1:0] wdata,
   input  logic              wdata_pop,
   output logic              wr_ovf,
   output logic              cs_conflict
);
   logic              clr_n;
   logic              hdr_push, dat_push, hdr_full, wr_full;
   logic [HDR_W-1:0]  hdr_word;
   logic [BYTE_W-1:0] dat_byte;
   logic              hdr_empty, wr_empty;
   logic              ovf_sck;
   logic [1:0]        csb_s;

   assign clr_n = rst_n & ~tpm_csb;

   tpmfe_rx #(.CNT_W(CNT_W)) u_rx (
      .sck(sck), .clr_n(clr_n), .sdi(sdi), .hdr_full(hdr_full),
      .hdr_push(hdr_push), .hdr_word(hdr_word),
      .dat_push(dat_push), .dat_byte(dat_byte));

   tpmfe_afifo #(.W(HDR_W), .DEPTH(HDR_DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_hdr_q (
      .wclk(sck), .wrst_n(rst_n), .wpush(hdr_push), .wdata(hdr_word), .wfull(hdr_full),
      .rclk(clk), .rrst_n(rst_n), .rpop(hdr_pop), .rdata(hdr_data), .rempty(hdr_empty));

   tpmfe_afifo #(.W(BYTE_W), .DEPTH(WR_DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_wr_q (
      .wclk(sck), .wrst_n(rst_n), .wpush(dat_push), .wdata(dat_byte), .wfull(wr_full),
      .rclk(clk), .rrst_n(rst_n), .rpop(wdata_pop), .rdata(wdata), .rempty(wr_empty));

   assign hdr_avail   = !hdr_empty;
   assign wdata_avail = !wr_empty;

   // sticky overflow, kept in the serial clock domain
   always_ff @(posedge sck or negedge rst_n) begin
      if (!rst_n) ovf_sck <= 1'b0;
      else if ((hdr_push && hdr_full) || (dat_push && wr_full)) ovf_sck <= 1'b1;
   end

   tpmfe_sync #(.STAGES(SYNC_STAGES), .W(1)) u_ovf_s (
      .clk(clk), .rst_n(rst_n), .d(ovf_sck), .q(wr_ovf));

   // select conflict watch in the core domain
   tpmfe_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_csb_s (
      .clk(clk), .rst_n(rst_n), .d({gen_csb, tpm_csb}), .q(csb_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_conflict <= 1'b0;
      else if (csb_s == 2'b00) cs_conflict <= 1'b1;
   end

   // R9
   conflict_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_conflict |=> cs_conflict);
   // R5
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ovf |=> wr_ovf);
   // R4
   hdr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_avail && !hdr_pop |=> hdr_avail);
   // R11
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdata_avail && !wdata_pop |=> wdata_avail && $stable(wdata));
endmodule

// File: tb/tpmfe_top_tb.sv
module tpmfe_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SCK_HALF   = 20;
   localparam int SETTLE     = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0;
   logic        gen_csb = 1'b1;
   logic        tpm_csb = 1'b1;
   logic        sdi = 1'b0;
   logic        hdr_pop = 1'b0;
   logic        wdata_pop = 1'b0;
   logic        hdr_avail, wdata_avail, wr_ovf, cs_conflict;
   logic [31:0] hdr_data;
   logic [7:0]  wdata;

   int total = 0;
   int bad   = 0;
   logic [7:0] dbuf [8];

   tpmfe_top u_dut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .gen_csb(gen_csb), .tpm_csb(tpm_csb),
      .sdi(sdi), .hdr_avail(hdr_avail), .hdr_data(hdr_data), .hdr_pop(hdr_pop),
      .wdata_avail(wdata_avail), .wdata(wdata), .wdata_pop(wdata_pop),
      .wr_ovf(wr_ovf), .cs_conflict(cs_conflict));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_hdr(input logic rd, input logic [5:0] szm1,
                                          input logic [23:0] addr);
      return {rd, 1'b0, szm1, addr};
   endfunction

   // bytes the write FIFO should hold after one transaction, no draining
   function automatic int exp_count(input logic [31:0] h, input int n);
      int lim;
      if (h[31]) return 0;
      lim = int'(h[29:24]) + 1;
      if (n < lim) lim = n;
      if (lim > 4) lim = 4;
      return lim;
   endfunction

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sdi = b[i];
         #(SCK_HALF) sck = 1'b1;
         #(SCK_HALF) sck = 1'b0;
      end
   endtask

   task automatic xfer(input logic [31:0] h, input int n);
      tpm_csb = 1'b0;
      #(SCK_HALF);
      for (int i = 3; i >= 0; i--) send_byte(h[8*i +: 8]);
      for (int i = 0; i < n; i++) send_byte(dbuf[i]);
      #(SCK_HALF) tpm_csb = 1'b1;
      repeat (SETTLE) @(negedge clk);
   endtask

   task automatic pop_hdr();
      hdr_pop = 1'b1;
      @(negedge clk) hdr_pop = 1'b0;
   endtask

   task automatic pop_wr();
      wdata_pop = 1'b1;
      @(negedge clk) wdata_pop = 1'b0;
   endtask

   task automatic drain_check(input string req, input logic [31:0] h, input int cnt);
      check({req, " hdr avail"}, 32'(hdr_avail), 32'd1);
      check({req, " hdr data"}, hdr_data, h);
      pop_hdr();
      check("R4 hdr level falls", 32'(hdr_avail), 32'd0);
      for (int k = 0; k < cnt; k++) begin
         check({req, " wr avail"}, 32'(wdata_avail), 32'd1);
         check({req, " wr byte"}, 32'(wdata), 32'(dbuf[k]));
         pop_wr();
      end
      check({req, " wr empty after drain"}, 32'(wdata_avail), 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] h;
      int n;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      // R10 reset state
      check("R10 hdr_avail", 32'(hdr_avail), 32'd0);
      check("R10 wdata_avail", 32'(wdata_avail), 32'd0);
      check("R10 wr_ovf", 32'(wr_ovf), 32'd0);
      check("R10 cs_conflict", 32'(cs_conflict), 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 R2 directed write of 3 bytes
      for (int i = 0; i < 8; i++) dbuf[i] = 8'(8'h11 * (i + 1));
      h = mk_hdr(1'b0, 6'd2, 24'hD40024);
      xfer(h, 3);
      drain_check("R1 R2 write", h, 3);

      // R2 size limit: size 2, host sends 4
      h = mk_hdr(1'b0, 6'd1, 24'h00ABCD);
      xfer(h, 4);
      drain_check("R2 size limit", h, 2);

      // R3 read command with trailing bytes
      h = mk_hdr(1'b1, 6'd3, 24'hFF0F00);
      xfer(h, 4);
      drain_check("R3 read no data", h, 0);

      // R11 pops on empty buffers change nothing
      pop_hdr();
      pop_wr();
      check("R11 hdr still empty", 32'(hdr_avail), 32'd0);
      check("R11 wr still empty", 32'(wdata_avail), 32'd0);
      for (int i = 0; i < 8; i++) dbuf[i] = 8'(8'hA0 + i);
      h = mk_hdr(1'b0, 6'd0, 24'h123456);
      xfer(h, 1);
      drain_check("R11 order after empty pop", h, 1);

      // R1 R2 R3 random transactions
      for (int t = 0; t < 30; t++) begin
         h = mk_hdr(1'($urandom), 6'($urandom_range(0, 3)), 24'($urandom));
         n = $urandom_range(0, 6);
         for (int i = 0; i < 8; i++) dbuf[i] = 8'($urandom);
         xfer(h, n);
         drain_check("R1 R2 R3 random", h, exp_count(h, n));
      end

      // R7 select raised in the middle of a byte
      tpm_csb = 1'b0;
      #(SCK_HALF);
      send_byte(8'h5A);
      for (int i = 0; i < 3; i++) begin
         sdi = 1'b1;
         #(SCK_HALF) sck = 1'b1;
         #(SCK_HALF) sck = 1'b0;
      end
      #(SCK_HALF) tpm_csb = 1'b1;
      repeat (SETTLE) @(negedge clk);
      check("R7 no header from aborted", 32'(hdr_avail), 32'd0);
      for (int i = 0; i < 8; i++) dbuf[i] = 8'(8'h3C ^ i);
      h = mk_hdr(1'b0, 6'd1, 24'h0A0B0C);
      xfer(h, 2);
      drain_check("R7 restart", h, 2);

      // R8 traffic under the generic select only
      gen_csb = 1'b0;
      #(SCK_HALF);
      for (int i = 0; i < 8; i++) send_byte(8'($urandom));
      #(SCK_HALF) gen_csb = 1'b1;
      repeat (SETTLE) @(negedge clk);
      check("R8 hdr untouched", 32'(hdr_avail), 32'd0);
      check("R8 wr untouched", 32'(wdata_avail), 32'd0);
      check("R9 no conflict yet", 32'(cs_conflict), 32'd0);

      // R5 write FIFO overflow: size 8, 6 bytes sent, no draining
      check("R5 ovf clear before", 32'(wr_ovf), 32'd0);
      for (int i = 0; i < 8; i++) dbuf[i] = 8'(8'hC0 + i);
      h = mk_hdr(1'b0, 6'd7, 24'h777777);
      xfer(h, 6);
      check("R5 ovf set", 32'(wr_ovf), 32'd1);
      drain_check("R5 first four kept", h, 4);
      check("R5 ovf sticky", 32'(wr_ovf), 32'd1);

      // R6 and R4: third header while two wait
      xfer(mk_hdr(1'b1, 6'd0, 24'h000001), 0);
      xfer(mk_hdr(1'b1, 6'd0, 24'h000002), 0);
      for (int i = 0; i < 8; i++) dbuf[i] = 8'(8'h90 + i);
      xfer(mk_hdr(1'b0, 6'd1, 24'h000003), 2);
      check("R6 dropped data absent", 32'(wdata_avail), 32'd0);
      check("R4 first kept", hdr_data, mk_hdr(1'b1, 6'd0, 24'h000001));
      pop_hdr();
      check("R4 level holds with one left", 32'(hdr_avail), 32'd1);
      check("R6 second kept", hdr_data, mk_hdr(1'b1, 6'd0, 24'h000002));
      pop_hdr();
      check("R6 third dropped", 32'(hdr_avail), 32'd0);

      // R9 both selects low together
      gen_csb = 1'b0;
      tpm_csb = 1'b0;
      repeat (5) @(negedge clk);
      gen_csb = 1'b1;
      tpm_csb = 1'b1;
      repeat (5) @(negedge clk);
      check("R9 conflict sticky", 32'(cs_conflict), 32'd1);
      check("R9 no header from conflict", 32'(hdr_avail), 32'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule